// File: doc/BRIEF.md
# Phase-Staggered Multi-Cell PWM Modulator

This block produces the switch commands for one phase leg made of several series-connected full-bridge cells. Every cell gets its own triangular carrier, an up/down counter running from 0 to a shared peak value and back. Each cell compares one signed reference sample against that carrier in a three-level unipolar scheme: the first half-bridge follows the reference, and the second half-bridge follows the negated reference. The carriers of neighbouring cells are staggered by 180/NCELL degrees, measured exactly in counts. This interleaves the cell pulses, so the summed phase voltage is a staircase with 2*NCELL+1 possible levels. Each cell is modulated on its own, so the power is shared evenly between the cells.

Reference samples arrive on a valid/ready stream. The sink takes a sample only when the carrier of cell 0 is at its valley, or while the block is idle. A producer holds `ref_valid` and `ref_data` steady until it sees `ref_ready` high at a rising edge. While it waits, the block keeps modulating with the sample it already holds. A sample takes effect in the cycle after the handshake.

The carrier peak is a plain control input. It is captured only while the block is idle, and it must be steady for two cycles before `enable` rises. Its value must be at least NCELL. When `enable` is sampled low, every gate goes low and the carriers return to their staggered start positions. `enable` is registered, so the block starts and stops one cycle after the input changes.

Top module: `psc_mlpwm`

## Requirements
- R1: After reset, all gate outputs are 0, `level` is 0 and `ref_ready` is 1.
- R2: While running, each carrier steps by exactly one count per cycle and traces 0,1,...,P,P-1,...,1,0,... with a period of 2P cycles, where P is the captured peak. The first high half-bridge (gate bit 4k+0) is on exactly when the signed reference is greater than carrier k.
- R3: The second high half-bridge (gate bit 4k+2) is on exactly when the negated reference is greater than carrier k. Negation is exact, including the most negative code.
- R4: In the first running cycle, carrier k starts at floor(k*P/NCELL) and counts upward.
- R5: A cell state is +1 when bit 4k+0 is on and bit 4k+2 is off, and -1 in the reverse case; otherwise it is 0. `level` is the signed two's-complement sum of the cell states and always lies in the range -NCELL..NCELL.
- R6: While running, each low switch is the complement of the high switch of the same half-bridge: bit 4k+1 is the complement of bit 4k+0, and bit 4k+3 is the complement of bit 4k+2. The high and low switch of one half-bridge are never on together.
- R7: One cycle after `enable` is low, all gates are 0 and `level` is 0. On the next start, every carrier restarts from its start position given in R4.
- R8: `ref_ready` is 1 when the block is idle, or when carrier 0 is at 0. A sample is taken on a cycle where `ref_valid` and `ref_ready` are both 1, and it is used from the next cycle. While `ref_ready` is 0, the held sample and the outputs are unaffected.
- R9: `period` is captured only while the block is idle. A change of `period` during a run leaves the carriers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run request; low forces all gates off |
| period | input | CW | Carrier peak count P (at least NCELL) |
| ref_valid | input | 1 | Reference sample valid |
| ref_ready | output | 1 | Block will accept a sample at this edge |
| ref_data | input | RW | Signed reference sample |
| gates | output | 4*NCELL | Per cell k: bit 4k+0 A high, 4k+1 A low, 4k+2 B high, 4k+3 B low |
| level | output | clog2(NCELL+1)+1 | Signed sum of the cell states |

## Verification
For three peak values, the bench sweeps every reference from beyond minus the peak to beyond plus the peak, plus the two extreme codes. It checks each gate and the level against a triangle computed arithmetically. A peak that does not divide by the cell count exposes offsets that are rounded the wrong way. The extreme negative code catches a negation that overflows, which would flip the second half-bridge to off. A valid sample held through a run shows whether the sink takes it in the middle of a period, which would bend the pulses early. Changing the peak during the run, then stopping and restarting, shows whether the period is captured at the wrong time, and whether a carrier keeps a stale phase that skews the staircase.

// File: rtl/pscpwm_pkg.sv
package pscpwm_pkg;

  typedef enum logic [1:0] {
    CELL_ZERO = 2'b00,
    CELL_POS  = 2'b01,
    CELL_NEG  = 2'b11
  } cell_state_e;

  // bit 0 is the upper switch of half-bridge A
  typedef struct packed {
    logic b_lo;
    logic b_hi;
    logic a_lo;
    logic a_hi;
  } gate_quad_t;

endpackage

// File: rtl/pscpwm_carrier.sv
module pscpwm_carrier #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] per,
  input  logic [CW-1:0] preload,
  output logic [CW-1:0] cnt
);

  logic up_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      up_q <= 1'b1;
    end else if (!run) begin
      cnt  <= preload;
      up_q <= 1'b1;
    end else if (cnt == '0) begin
      cnt  <= CW'(1);
      up_q <= 1'b1;
    end else if (cnt >= per) begin
      cnt  <= cnt - 1'b1;
      up_q <= 1'b0;
    end else if (up_q) begin
      cnt  <= cnt + 1'b1;
    end else begin
      cnt  <= cnt - 1'b1;
    end
  end

  // R2: a running carrier moves by one count per cycle
  p_carrier_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> ((cnt == $past(cnt) + 1'b1) || (cnt + 1'b1 == $past(cnt))));

endmodule

// File: rtl/pscpwm_cell.sv
module pscpwm_cell
  import pscpwm_pkg::*;
#(
  parameter int CW = 8,
  parameter int RW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic signed [RW-1:0] ref_q,
  input  logic [CW-1:0]        cnt,
  output gate_quad_t           gates,
  output cell_state_e          state
);

  localparam int XW = ((RW > CW) ? RW : CW) + 2;

  logic signed [XW-1:0] ref_x, neg_x, car_x;
  logic leg_a, leg_b;

  always_comb begin
    ref_x = XW'(ref_q);
    neg_x = -ref_x;
    car_x = signed'(XW'(cnt));
    leg_a = run && (ref_x > car_x);
    leg_b = run && (neg_x > car_x);
  end

  always_comb begin
    gates.a_hi = leg_a;
    gates.a_lo = run & ~leg_a;
    gates.b_hi = leg_b;
    gates.b_lo = run & ~leg_b;
  end

  always_comb begin
    case ({gates.a_hi, gates.b_hi})
      2'b10:   state = CELL_POS;
      2'b01:   state = CELL_NEG;
      default: state = CELL_ZERO;
    endcase
  end

  // R6: never both switches of one half-bridge
  p_no_shoot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(gates.a_hi && gates.a_lo) && !(gates.b_hi && gates.b_lo));

  // R5: the two half-bridges never both drive high
  p_legs_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(gates.a_hi && gates.b_hi));

endmodule

// File: rtl/pscpwm_level.sv
module pscpwm_level
  import pscpwm_pkg::*;
#(
  parameter int N  = 3,
  parameter int LW = 3
) (
  input  cell_state_e            st [N],
  output logic signed [LW-1:0]   level
);

  logic [LW-1:0] pos_n, neg_n;

  always_comb begin
    pos_n = '0;
    neg_n = '0;
    for (int i = 0; i < N; i++) begin
      if (st[i] == CELL_POS) pos_n = pos_n + 1'b1;
      if (st[i] == CELL_NEG) neg_n = neg_n + 1'b1;
    end
    level = signed'(pos_n - neg_n);
  end

endmodule

// File: rtl/psc_mlpwm.sv
module psc_mlpwm
  import pscpwm_pkg::*;
#(
  parameter int NCELL = 3,
  parameter int CW    = 8,
  parameter int RW    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          enable,
  input  logic [CW-1:0]                 period,
  input  logic                          ref_valid,
  output logic                          ref_ready,
  input  logic signed [RW-1:0]          ref_data,
  output logic [4*NCELL-1:0]            gates,
  output logic signed [$clog2(NCELL+1):0] level
);

  localparam int LW = $clog2(NCELL + 1) + 1;
  localparam int PW = CW + $clog2(NCELL) + 1;

  logic                 run_q;
  logic [CW-1:0]        per_q;
  logic signed [RW-1:0] ref_q;

  logic [CW-1:0] cnt [NCELL];
  gate_quad_t    quad [NCELL];
  cell_state_e   st [NCELL];

  assign ref_ready = !run_q || (cnt[0] == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      per_q <= '0;
      ref_q <= '0;
    end else begin
      run_q <= enable;
      if (!run_q) per_q <= period;
      if (ref_valid && ref_ready) ref_q <= ref_data;
    end
  end

  for (genvar k = 0; k < NCELL; k++) begin : g_cell
    logic [PW-1:0] prod;
    logic [CW-1:0] preload;

    assign prod    = PW'(per_q) * PW'(k);
    assign preload = CW'(prod / PW'(NCELL));

    pscpwm_carrier #(.CW(CW)) u_car (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_q),
      .per     (per_q),
      .preload (preload),
      .cnt     (cnt[k])
    );

    pscpwm_cell #(.CW(CW), .RW(RW)) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run_q),
      .ref_q (ref_q),
      .cnt   (cnt[k]),
      .gates (quad[k]),
      .state (st[k])
    );

    assign gates[4*k +: 4] = quad[k];
  end

  pscpwm_level #(.N(NCELL), .LW(LW)) u_level (
    .st    (st),
    .level (level)
  );

  // R7: idle means every switch off and a zero level
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (gates == '0 && level == '0));

  // R5: level stays within the cell count
  p_level_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (level <= NCELL) && (level >= -NCELL));

  // R8: held sample only changes on a handshake
  p_ref_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ref_valid && ref_ready) |=> $stable(ref_q));

  // R9: peak is frozen during a run
  p_period_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run_q) |-> $stable(per_q));

endmodule

// File: tb/tb_psc_mlpwm.sv
`timescale 1ns/1ps
module tb_psc_mlpwm;

  localparam int NC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [7:0] period = 8'd6;
  logic ref_valid = 1'b0;
  logic ref_ready;
  logic signed [7:0] ref_data = '0;
  logic [4*NC-1:0] gates;
  logic signed [2:0] level;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  psc_mlpwm #(.NCELL(NC), .CW(8), .RW(8)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .period(period),
    .ref_valid(ref_valid), .ref_ready(ref_ready), .ref_data(ref_data),
    .gates(gates), .level(level)
  );

  function automatic int tri_at(int p, int k, int j);
    int pos;
    pos = ((k * p) / NC + j) % (2 * p);
    return (pos <= p) ? pos : 2 * p - pos;
  endfunction

  task automatic check_run(int p, int r, int j, string tag);
    logic [4*NC-1:0] eg;
    int el;
    int c;
    eg = '0;
    el = 0;
    for (int k = 0; k < NC; k++) begin
      c = tri_at(p, k, j);
      eg[4*k+0] = (r > c);
      eg[4*k+1] = !(r > c);
      eg[4*k+2] = (-r > c);
      eg[4*k+3] = !(-r > c);
      if (r > c) el = el + 1;
      if (-r > c) el = el - 1;
    end
    total++;
    if (gates !== eg || int'(level) != el) begin
      bad++;
      $display("FAIL %s p=%0d r=%0d j=%0d gates=%h exp=%h level=%0d exp=%0d",
               tag, p, r, j, gates, eg, level, el);
    end
  endtask

  task automatic check_quiet(string tag);
    total++;
    if (gates !== '0 || level !== '0 || ref_ready !== 1'b1) begin
      bad++;
      $display("FAIL %s gates=%h exp=0 level=%0d exp=0 ready=%b exp=1",
               tag, gates, level, ref_ready);
    end
  endtask

  task automatic check_ready(int p, int j, string tag);
    logic er;
    er = (tri_at(p, 0, j) == 0);
    total++;
    if (ref_ready !== er) begin
      bad++;
      $display("FAIL %s j=%0d ready=%b exp=%b", tag, j, ref_ready, er);
    end
  endtask

  // stop, load peak and sample while idle, start; returns at j=0 sample point
  task automatic start_run(int p, int r);
    @(negedge clk) enable = 1'b0;
    @(negedge clk);
    period = p[7:0];
    ref_data = r[7:0];
    ref_valid = 1'b1;
    @(negedge clk) ref_valid = 1'b0;
    check_quiet("R7 idle");
    @(negedge clk);
    @(negedge clk) enable = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int pv [3] = '{6, 7, 9};
    int cur;
    logic acc;
    repeat (3) @(negedge clk);
    check_quiet("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_quiet("R1 after reset");

    // R2 R3 R4 R5 R6: reference sweep for several peaks
    foreach (pv[i]) begin
      for (int r = -pv[i] - 2; r <= pv[i] + 2; r++) begin
        start_run(pv[i], r);
        for (int j = 0; j < 4 * pv[i]; j++) begin
          check_run(pv[i], r, j, "R2 R3 R4 R5 R6 sweep");
          @(negedge clk);
        end
      end
    end

    // R3 extreme codes
    start_run(6, -128);
    for (int j = 0; j < 12; j++) begin
      check_run(6, -128, j, "R3 most negative");
      @(negedge clk);
    end
    start_run(6, 127);
    for (int j = 0; j < 12; j++) begin
      check_run(6, 127, j, "R2 most positive");
      @(negedge clk);
    end

    // R7: stop mid-run, stay quiet, restart from offsets
    start_run(7, 5);
    for (int j = 0; j < 5; j++) begin
      check_run(7, 5, j, "R7 before stop");
      @(negedge clk);
    end
    enable = 1'b0;
    @(negedge clk);
    for (int j = 0; j < 3; j++) begin
      check_quiet("R7 stopped");
      @(negedge clk);
    end
    enable = 1'b1;
    @(negedge clk);
    for (int j = 0; j < 14; j++) begin
      check_run(7, 5, j, "R7 R4 restart");
      @(negedge clk);
    end

    // R8 handshake at valley, R9 peak change ignored while running
    start_run(6, 2);
    cur = 2;
    acc = 1'b0;
    for (int j = 0; j < 36; j++) begin
      if (acc) begin
        cur = -3;
        ref_valid = 1'b0;
        acc = 1'b0;
      end
      check_run(6, cur, j, "R8 R9 stream");
      check_ready(6, j, "R8 ready");
      if (ref_valid && tri_at(6, 0, j) == 0) acc = 1'b1;
      if (j == 1) begin
        ref_valid = 1'b1;
        ref_data = -8'sd3;
      end
      if (j == 3) period = 8'd9;
      @(negedge clk);
    end
    total++;
    if (cur != -3) begin
      bad++;
      $display("FAIL R8 sample not taken cur=%0d exp=-3", cur);
    end

    // R9: new peak applies after stop
    start_run(9, 4);
    for (int j = 0; j < 18; j++) begin
      check_run(9, 4, j, "R9 new peak");
      @(negedge clk);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule